// File: doc/BRIEF.md
# Configurable Aspect-Ratio Dual-Port Memory

This block is a 4096-bit storage array with two ports that can be seen as 4096 one-bit words, 2048 two-bit words, 1024 four-bit words or 512 eight-bit words. A static width selector picks the word shape. Both ports read from and write to the same bit array, so data written in one shape can be read back in another. A static mode selector makes the block a two-port RAM, a one-port RAM (port B silent) or a read-only table whose contents come only from the `INIT` parameter.

Each port presents an address, write data and a write strobe, and both ports may act in the same cycle. All port inputs are captured on the input clock. The word read at that edge feeds either the read-data pin directly or a per-port output register on a separate output clock. The output registers clear asynchronously on reset. Each clock has an inversion control, so either edge can be the active one.

The mode decode names four operating states. DUAL lets both ports read and write. SINGLE gates port B off. ROM and ROM_ALT block writes on both ports. There are no transitions between them at run time: a new state is chosen only while reset is held.

Top module: `cfgmem_dp`

## Requirements
- R1: `width_sel` values 0, 1, 2 and 3 give word widths of 1, 2, 4 and 8 bits, with 4096, 2048, 1024 and 512 words. Address bits above the used depth are ignored, and read-data bits above the word width read as zero.
- R2: Word `i` at width `w` occupies array bits `i*w` to `i*w+w-1`, so data written at one width reads back consistently at another.
- R3: The two ports act independently in the same cycle. When both write the same bit, port A's value is stored.
- R4: A port that reads the word being written at the same capture edge returns the data held before that write.
- R5: With the output register bypassed (`x_oreg`=0), read data for a captured address appears at `x_rdata` right after the input-clock edge that captured it.
- R6: With the output register in use (`x_oreg`=1), `x_rdata` takes the word on the next active output-clock edge after the input-clock capture.
- R7: While `rst_n` is low, both read-data outputs are zero without waiting for any clock edge.
- R8: `in_clk_inv`=1 makes the falling edge of `in_clk` the capture edge, and `out_clk_inv`=1 does the same for `out_clk`.
- R9: `mem_mode` 2'b10 or 2'b11 (ROM) ignores writes on both ports.
- R10: `mem_mode` 2'b01 (SINGLE) holds `b_rdata` at zero and ignores port B writes, while port A works normally. `mem_mode` 2'b00 is DUAL.
- R11: Bit `n` of the `INIT` parameter is array bit `n` from time zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Capture clock for port inputs and writes |
| in_clk_inv | input | 1 | 1 selects the falling edge of in_clk |
| out_clk | input | 1 | Clock for the optional output registers |
| out_clk_inv | input | 1 | 1 selects the falling edge of out_clk |
| rst_n | input | 1 | Active-low asynchronous reset of the read-data registers |
| width_sel | input | 2 | Word width select, static |
| mem_mode | input | 2 | 00 DUAL, 01 SINGLE, 10/11 ROM, static |
| a_oreg | input | 1 | Port A uses its output register |
| b_oreg | input | 1 | Port B uses its output register |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 8 | Port A write data, low bits used |
| a_we | input | 1 | Port A write strobe |
| a_rdata | output | 8 | Port A read data |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 8 | Port B write data, low bits used |
| b_we | input | 1 | Port B write strobe |
| b_rdata | output | 8 | Port B read data |

## Verification
A wrong bit in the array stays hidden until some port reads a word that covers it. It then shows one capture edge later on a bypassed port, or one output edge after that on a registered port. A wrong offset or lane mask shows up as a mismatch when data is written at one width and read at another, or as nonzero bits above the word width. A stale read-stage register shows on the first read after a write to the same word, while a port collision resolved the wrong way shows on the next read of the contested word.

// File: rtl/cfgmem_pkg.sv
`timescale 1ns/1ps
package cfgmem_pkg;

    // Operating states of the mode decode
    typedef enum logic [1:0] {
        MODE_DUAL    = 2'b00,
        MODE_SINGLE  = 2'b01,
        MODE_ROM     = 2'b10,
        MODE_ROM_ALT = 2'b11
    } mem_mode_e;

endpackage

// File: rtl/cfgmem_lane.sv
`timescale 1ns/1ps
// Per-port address and data alignment onto the flat bit array.
module cfgmem_lane #(
    parameter int unsigned TOTAL_BITS = 4096,
    parameter int unsigned MAX_W      = 8,
    localparam int unsigned AW        = $clog2(TOTAL_BITS),
    localparam int unsigned SEL_W     = $clog2($clog2(MAX_W) + 1)
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [AW-1:0]         addr,
    input  logic [MAX_W-1:0]      wdata,
    input  logic                  we,
    input  logic                  wr_ok,
    output logic [AW-1:0]         off,
    output logic [MAX_W-1:0]      lmask,
    output logic [TOTAL_BITS-1:0] wmask,
    output logic [TOTAL_BITS-1:0] wbits
);

    logic [AW-1:0]         amask;
    logic [TOTAL_BITS-1:0] lane_wide;
    logic [TOTAL_BITS-1:0] data_wide;

    always_comb begin
        // depth shrinks as the word widens: keep only the used address bits
        amask     = AW'((TOTAL_BITS >> sel) - 1);
        off       = (addr & amask) << sel;
        lmask     = MAX_W'((1 << (1 << sel)) - 1);
        lane_wide = {{(TOTAL_BITS-MAX_W){1'b0}}, lmask} << off;
        data_wide = {{(TOTAL_BITS-MAX_W){1'b0}}, wdata & lmask} << off;
        wmask     = (we && wr_ok) ? lane_wide : '0;
        wbits     = data_wide;
    end

endmodule

// File: rtl/cfgmem_array.sv
`timescale 1ns/1ps
// Shared bit array: masked writes (port 0 applied last, so it wins) and
// read-stage registers that capture the pre-write word.
module cfgmem_array #(
    parameter int unsigned            TOTAL_BITS = 4096,
    parameter int unsigned            MAX_W      = 8,
    parameter int unsigned            NPORT      = 2,
    parameter logic [TOTAL_BITS-1:0]  INIT       = '0,
    localparam int unsigned           AW         = $clog2(TOTAL_BITS)
) (
    input  logic                  iclk,
    input  logic                  rst_n,
    input  logic [TOTAL_BITS-1:0] wmask [NPORT],
    input  logic [TOTAL_BITS-1:0] wbits [NPORT],
    input  logic [AW-1:0]         off   [NPORT],
    input  logic [MAX_W-1:0]      lmask [NPORT],
    input  logic [NPORT-1:0]      rd_ok,
    output logic [MAX_W-1:0]      rd_q  [NPORT]
);

    logic [TOTAL_BITS-1:0] mem_q = INIT;
    logic [TOTAL_BITS-1:0] mem_d;
    logic [MAX_W-1:0]      word  [NPORT];

    always_comb begin
        mem_d = mem_q;
        for (int p = NPORT - 1; p >= 0; p--) begin
            mem_d = (mem_d & ~wmask[p]) | (wbits[p] & wmask[p]);
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            word[p] = MAX_W'(mem_q >> off[p]) & lmask[p];
        end
    end

    always_ff @(posedge iclk) begin
        mem_q <= mem_d;
    end

    always_ff @(posedge iclk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPORT; p++) rd_q[p] <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) rd_q[p] <= rd_ok[p] ? word[p] : '0;
        end
    end

    // R3: bits written by both ports hold port A's data afterwards
    a_r3_port_a_wins: assert property (@(posedge iclk) disable iff (!rst_n)
        ((wmask[0] & wmask[1]) != '0) |=>
        ((mem_q & $past(wmask[0] & wmask[1])) == $past(wbits[0] & wmask[0] & wmask[1])));

endmodule

// File: rtl/cfgmem_oreg.sv
`timescale 1ns/1ps
// Optional per-port output register with asynchronous clear.
module cfgmem_oreg #(
    parameter int unsigned W = 8
) (
    input  logic         oclk,
    input  logic         rst_n,
    input  logic         use_reg,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    always_ff @(posedge oclk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
    end

    assign q = use_reg ? q_r : d;

    // R7: the register leaves reset holding zero
    a_r7_clear_on_release: assert property (@(posedge oclk) disable iff (!rst_n)
        $rose(rst_n) |-> (q_r == '0));

endmodule

// File: rtl/cfgmem_dp.sv
`timescale 1ns/1ps
module cfgmem_dp
    import cfgmem_pkg::*;
#(
    parameter int unsigned           TOTAL_BITS = 4096,
    parameter int unsigned           MAX_W      = 8,
    parameter logic [TOTAL_BITS-1:0] INIT       = '0,
    localparam int unsigned          AW         = $clog2(TOTAL_BITS),
    localparam int unsigned          SEL_W      = $clog2($clog2(MAX_W) + 1)
) (
    input  logic             in_clk,
    input  logic             in_clk_inv,
    input  logic             out_clk,
    input  logic             out_clk_inv,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] width_sel,
    input  logic [1:0]       mem_mode,
    input  logic             a_oreg,
    input  logic             b_oreg,
    input  logic [AW-1:0]    a_addr,
    input  logic [MAX_W-1:0] a_wdata,
    input  logic             a_we,
    output logic [MAX_W-1:0] a_rdata,
    input  logic [AW-1:0]    b_addr,
    input  logic [MAX_W-1:0] b_wdata,
    input  logic             b_we,
    output logic [MAX_W-1:0] b_rdata
);

    localparam int unsigned NPORT = 2;

    logic            iclk;
    logic            oclk;
    mem_mode_e       mode_s;
    logic [NPORT-1:0] wr_ok;
    logic [NPORT-1:0] rd_ok;

    logic [AW-1:0]         addr_v  [NPORT];
    logic [MAX_W-1:0]      wdata_v [NPORT];
    logic [NPORT-1:0]      we_v;
    logic [NPORT-1:0]      oreg_v;
    logic [AW-1:0]         off_v   [NPORT];
    logic [MAX_W-1:0]      lmask_v [NPORT];
    logic [TOTAL_BITS-1:0] wmask_v [NPORT];
    logic [TOTAL_BITS-1:0] wbits_v [NPORT];
    logic [MAX_W-1:0]      rd_v    [NPORT];
    logic [MAX_W-1:0]      q_v     [NPORT];

    // clock polarity selection
    assign iclk = in_clk ^ in_clk_inv;
    assign oclk = out_clk ^ out_clk_inv;

    assign mode_s = mem_mode_e'(mem_mode);

    // operating-state decode
    always_comb begin
        unique case (mode_s)
            MODE_DUAL: begin
                wr_ok = 2'b11;
                rd_ok = 2'b11;
            end
            MODE_SINGLE: begin
                wr_ok = 2'b01;
                rd_ok = 2'b01;
            end
            MODE_ROM, MODE_ROM_ALT: begin
                wr_ok = 2'b00;
                rd_ok = 2'b11;
            end
        endcase
    end

    assign addr_v[0]  = a_addr;
    assign addr_v[1]  = b_addr;
    assign wdata_v[0] = a_wdata;
    assign wdata_v[1] = b_wdata;
    assign we_v       = {b_we, a_we};
    assign oreg_v     = {b_oreg, a_oreg};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        cfgmem_lane #(.TOTAL_BITS(TOTAL_BITS), .MAX_W(MAX_W)) u_lane (
            .sel   (width_sel),
            .addr  (addr_v[p]),
            .wdata (wdata_v[p]),
            .we    (we_v[p]),
            .wr_ok (wr_ok[p]),
            .off   (off_v[p]),
            .lmask (lmask_v[p]),
            .wmask (wmask_v[p]),
            .wbits (wbits_v[p])
        );

        cfgmem_oreg #(.W(MAX_W)) u_oreg (
            .oclk    (oclk),
            .rst_n   (rst_n),
            .use_reg (oreg_v[p]),
            .d       (rd_v[p]),
            .q       (q_v[p])
        );
    end

    cfgmem_array #(
        .TOTAL_BITS (TOTAL_BITS),
        .MAX_W      (MAX_W),
        .NPORT      (NPORT),
        .INIT       (INIT)
    ) u_array (
        .iclk  (iclk),
        .rst_n (rst_n),
        .wmask (wmask_v),
        .wbits (wbits_v),
        .off   (off_v),
        .lmask (lmask_v),
        .rd_ok (rd_ok),
        .rd_q  (rd_v)
    );

    assign a_rdata = q_v[0];
    assign b_rdata = q_v[1];

    // R1: bits above the word width never reach the read-data pins
    a_r1_upper_zero: assert property (@(posedge oclk) disable iff (!rst_n)
        ((a_rdata & ~lmask_v[0]) == '0) && ((b_rdata & ~lmask_v[1]) == '0));

    // R10: port B stays silent in the single-port state
    a_r10_b_silent: assert property (@(posedge oclk) disable iff (!rst_n)
        (mode_s == MODE_SINGLE) |-> (b_rdata == '0));

    // R9: the array does not change while in a read-only state
    a_r9_rom_frozen: assert property (@(posedge iclk) disable iff (!rst_n)
        (mode_s == MODE_ROM || mode_s == MODE_ROM_ALT) |=> $stable(u_array.mem_q));

endmodule

// File: tb/cfgmem_dp_bench.sv
`timescale 1ns/1ps
module cfgmem_dp_bench;

    localparam logic [1:0] M_DUAL = 2'b00;
    localparam logic [1:0] M_SP   = 2'b01;
    localparam logic [1:0] M_ROM  = 2'b10;

    function automatic logic [4095:0] make_img();
        logic [4095:0] r;
        for (int i = 0; i < 4096; i++) r[i] = 1'(((i * 37) + 11) >> 3);
        return r;
    endfunction

    localparam logic [4095:0] IMG = make_img();

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        iinv = 1'b0, oinv = 1'b0;
    logic [1:0]  sel = 2'd3, mode = M_ROM;
    logic        aoreg = 1'b0, boreg = 1'b0;
    logic [11:0] a_addr = '0, b_addr = '0;
    logic [7:0]  a_wd = '0, b_wd = '0;
    logic        a_we = 1'b0, b_we = 1'b0;
    logic [7:0]  a_rd, b_rd;

    logic [4095:0] mdl = IMG;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    cfgmem_dp #(.INIT(IMG)) u_cfgmem_dp (
        .in_clk(clk), .in_clk_inv(iinv), .out_clk(clk), .out_clk_inv(oinv),
        .rst_n(rst_n), .width_sel(sel), .mem_mode(mode),
        .a_oreg(aoreg), .b_oreg(boreg),
        .a_addr(a_addr), .a_wdata(a_wd), .a_we(a_we), .a_rdata(a_rd),
        .b_addr(b_addr), .b_wdata(b_wd), .b_we(b_we), .b_rdata(b_rd)
    );

    function automatic logic [7:0] mword(input logic [1:0] s, input logic [11:0] ad);
        int w = 1 << s;
        int base = (int'(ad) % (4096 >> s)) * w;
        logic [7:0] r = '0;
        for (int k = 0; k < w; k++) r[k] = mdl[base + k];
        return r;
    endfunction

    task automatic mput(input logic [1:0] s, input logic [11:0] ad, input logic [7:0] d);
        int w = 1 << s;
        int base = (int'(ad) % (4096 >> s)) * w;
        for (int k = 0; k < w; k++) mdl[base + k] = d[k];
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic [1:0] s, input logic [1:0] m, input logic ao,
                       input logic bo, input logic ii, input logic oi);
        a_we = 1'b0; b_we = 1'b0;
        rst_n = 1'b0;
        sel = s; mode = m; aoreg = ao; boreg = bo; iinv = ii; oinv = oi;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr2(input logic ae, input logic [11:0] aa, input logic [7:0] ad,
                       input logic be, input logic [11:0] ba, input logic [7:0] bd);
        a_we = ae; a_addr = aa; a_wd = ad;
        b_we = be; b_addr = ba; b_wd = bd;
        tick();
        a_we = 1'b0; b_we = 1'b0;
        if (mode == M_DUAL) begin
            if (be) mput(sel, ba, bd);
            if (ae) mput(sel, aa, ad);
        end else if (mode == M_SP) begin
            if (ae) mput(sel, aa, ad);
        end
    endtask

    task automatic rd_a(input logic [11:0] ad, input string req);
        a_addr = ad;
        repeat (3) tick();
        chk(req, a_rd, mword(sel, ad));
    endtask

    task automatic rd_b(input logic [11:0] ad, input string req);
        b_addr = ad;
        repeat (3) tick();
        chk(req, b_rd, (mode == M_SP) ? 8'h00 : mword(sel, ad));
    endtask

    // R7, R11: reset state and initial image
    task automatic t_reset_init();
        rst_n = 1'b0;
        sel = 2'd3; mode = M_ROM; aoreg = 1'b1; boreg = 1'b1;
        a_addr = 12'd100; b_addr = 12'd7;
        repeat (3) tick();
        chk("R7 reset a", a_rd, 8'h00);
        chk("R7 reset b", b_rd, 8'h00);
        rst_n = 1'b1;
        tick();
        rd_a(12'd0,   "R11 image a0");
        rd_a(12'd100, "R11 image a100");
        rd_a(12'd511, "R11 image a511");
        rd_b(12'd7,   "R11 image b7");
    endtask

    // R9: writes ignored in both read-only encodings
    task automatic t_rom();
        wr2(1'b1, 12'd5, 8'h5A, 1'b1, 12'd6, 8'hA5);
        rd_a(12'd5, "R9 rom a5");
        rd_b(12'd6, "R9 rom b6");
        chk("R9 rom image", mword(2'd3, 12'd5), IMG[47:40]);
        cfg(2'd3, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        wr2(1'b1, 12'd9, 8'hFF, 1'b1, 12'd9, 8'h00);
        rd_a(12'd9, "R9 rom_alt a9");
        chk("R9 rom_alt image", a_rd, IMG[79:72]);
    endtask

    // R1: every width, address aliasing, upper bits zero
    task automatic t_widths();
        for (int s = 0; s < 4; s++) begin
            cfg(2'(s), M_DUAL, 1'b0, 1'b1, 1'b0, 1'b0);
            wr2(1'b1, 12'd3, 8'hFF, 1'b1, 12'd4, 8'hA6);
            rd_b(12'd3, "R1 width b reads a");
            chk("R1 upper zero", b_rd, 8'((1 << (1 << s)) - 1));
            rd_a(12'd4, "R1 width a reads b");
            wr2(1'b1, 12'hE02 | 12'(12'hFFF >> (s + 4)), 8'h96, 1'b0, 12'd0, 8'h00);
            rd_a(12'(12'hFFF >> (s + 4)), "R1 alias");
        end
    endtask

    // R2: cross-width consistency
    task automatic t_cross();
        cfg(2'd3, M_DUAL, 1'b0, 1'b0, 1'b0, 1'b0);
        wr2(1'b1, 12'd10, 8'hA5, 1'b0, 12'd0, 8'h00);
        cfg(2'd0, M_DUAL, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 80; k < 88; k++) rd_a(12'(k), "R2 bit view");
        chk("R2 bit 80", a_rd, 8'h01);
        cfg(2'd2, M_DUAL, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_b(12'd20, "R2 nibble lo");
        chk("R2 nibble lo value", b_rd, 8'h05);
        rd_b(12'd21, "R2 nibble hi");
        chk("R2 nibble hi value", b_rd, 8'h0A);
    endtask

    // R3: same-cycle access, collision priority
    task automatic t_collide();
        cfg(2'd3, M_DUAL, 1'b0, 1'b0, 1'b0, 1'b0);
        wr2(1'b1, 12'd20, 8'h3C, 1'b1, 12'd20, 8'hC3);
        rd_b(12'd20, "R3 a wins");
        chk("R3 a wins value", b_rd, 8'h3C);
        wr2(1'b1, 12'd21, 8'h12, 1'b1, 12'd22, 8'h34);
        rd_a(12'd22, "R3 both land b");
        rd_b(12'd21, "R3 both land a");
    endtask

    // R4: read during write returns old data
    task automatic t_rdw();
        logic [7:0] old;
        cfg(2'd3, M_DUAL, 1'b0, 1'b0, 1'b0, 1'b0);
        wr2(1'b1, 12'd30, 8'h77, 1'b0, 12'd0, 8'h00);
        rd_a(12'd30, "R4 setup");
        old = 8'h77;
        a_addr = 12'd30; a_wd = 8'h88; a_we = 1'b1;
        tick();
        a_we = 1'b0;
        chk("R4 old data", a_rd, old);
        mput(2'd3, 12'd30, 8'h88);
        tick();
        chk("R4 new data next", a_rd, 8'h88);
    endtask

    // R5, R6: output timing with and without register
    task automatic t_latency();
        cfg(2'd3, M_DUAL, 1'b0, 1'b0, 1'b0, 1'b0);
        wr2(1'b1, 12'd50, 8'h11, 1'b1, 12'd51, 8'h22);
        rd_a(12'd50, "R5 setup");
        a_addr = 12'd51;
        tick();
        chk("R5 bypass one edge", a_rd, 8'h22);
        cfg(2'd3, M_DUAL, 1'b1, 1'b0, 1'b0, 1'b0);
        rd_a(12'd50, "R6 setup");
        a_addr = 12'd51;
        tick();
        chk("R6 not yet", a_rd, 8'h11);
        tick();
        chk("R6 after out edge", a_rd, 8'h22);
    endtask

    // R8: clock polarity
    task automatic t_polarity();
        cfg(2'd3, M_DUAL, 1'b0, 1'b0, 1'b1, 1'b0);
        rd_a(12'd50, "R8 setup inv");
        a_addr = 12'd51;
        #2;
        chk("R8 falling capture", a_rd, 8'h22);
        tick();
        cfg(2'd3, M_DUAL, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_a(12'd50, "R8 setup norm");
        a_addr = 12'd51;
        #2;
        chk("R8 rising waits", a_rd, 8'h11);
        tick();
        cfg(2'd3, M_DUAL, 1'b1, 1'b0, 1'b0, 1'b1);
        rd_a(12'd50, "R8 setup out inv");
        a_addr = 12'd51;
        tick();
        #2;
        chk("R8 out falling", a_rd, 8'h22);
        tick();
        cfg(2'd3, M_DUAL, 1'b1, 1'b0, 1'b0, 1'b0);
        rd_a(12'd50, "R8 setup out norm");
        a_addr = 12'd51;
        tick();
        #2;
        chk("R8 out rising waits", a_rd, 8'h11);
        tick();
    endtask

    // R10: single-port state
    task automatic t_single();
        cfg(2'd3, M_DUAL, 1'b0, 1'b0, 1'b0, 1'b0);
        wr2(1'b0, 12'd0, 8'h00, 1'b1, 12'd40, 8'h5C);
        cfg(2'd3, M_SP, 1'b0, 1'b1, 1'b0, 1'b0);
        rd_b(12'd40, "R10 b zero");
        chk("R10 b zero value", b_rd, 8'h00);
        wr2(1'b1, 12'd41, 8'h61, 1'b1, 12'd40, 8'hE7);
        rd_a(12'd41, "R10 a works");
        cfg(2'd3, M_DUAL, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_a(12'd40, "R10 b write ignored");
        chk("R10 b write ignored value", a_rd, 8'h5C);
    endtask

    // R7: asynchronous clear mid-cycle
    task automatic t_async_clear();
        cfg(2'd3, M_DUAL, 1'b1, 1'b0, 1'b0, 1'b0);
        rd_a(12'd51, "R7 setup");
        #1;
        rst_n = 1'b0;
        #0.5;
        chk("R7 async clear", a_rd, 8'h00);
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        t_reset_init();
        t_rom();
        t_widths();
        t_cross();
        t_collide();
        t_rdw();
        t_latency();
        t_polarity();
        t_single();
        t_async_clear();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule